// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a processor core and its instruction memory. It keeps a short circular queue of instruction words, and each word is stored with the word address it came from. Every cycle the core presents its program counter. The queue serves the matching instruction when the oldest queued entry belongs to that address. When the address does not match, the queue discards its contents. It then keeps itself filled by fetching sequential words through a request/response memory port. Only one request is outstanding at a time.

The queue serves whole 32-bit words in word mode and 16-bit halfwords in compact mode. In compact mode the lower halfword of an entry is read without consuming it, and reading the upper halfword retires the entry. When address translation is enabled, a translation-fault input stops the refill in progress. A debug lookup port reports which slot holds a given address.

The refill control is a five-state machine:
- `RF_IDLE`: the queue is full.
- `RF_REQ`: a request is being presented.
- `RF_WAIT`: the response is awaited.
- `RF_DRAIN`: a response made stale by a flush is awaited and discarded.
- `RF_FAULT`: the refill is parked after a translation fault.

Transitions:
- IDLE→REQ when room appears.
- REQ→WAIT on a handshake.
- REQ→FAULT on a fault.
- WAIT→REQ or WAIT→IDLE on a response, depending on remaining room.
- WAIT→DRAIN on a flush without a response.
- DRAIN→REQ on the discarded response.
- FAULT→REQ on a flush or a pop.
- A flush in REQ stays in REQ with the new address.

Top module: `insn_prefetch_queue`

## Requirements
- R1: Reset empties the queue (count and read index zero), clears every slot's stored address to zero, and holds `insn_valid` and `mem_req_valid` low.
- R2: The two low bits of `core_pc` are ignored when comparing against stored addresses. The aligned PC is `{core_pc[31:2], 2'b00}`.
- R3: When the queue is non-empty and the head entry's address differs from the aligned PC, the queue flushes: count and read index become zero, any outstanding response is discarded, and refilling restarts at the aligned PC. When the queue is empty, a flush happens when the aligned PC differs from the next fetch address.
- R4: Refill requests go out one at a time, only while the queue has room, never during a flush cycle, and never while a response is outstanding. The first fetch after a flush uses the aligned PC, and each stored word advances the next address by 4, so the next address is always the head address plus 4 × count.
- R5: A returned word is written to slot (read index + count) mod DEPTH, which equals (read index − words still to fetch) mod DEPTH.
- R6: While `xlat_en` and `xlat_fault` are both high, no request is issued, and the refill parks until the next flush or pop. With `xlat_en` low, `xlat_fault` has no effect.
- R7: `insn_valid` is high exactly when the count is non-zero and the head address equals the aligned PC. In word mode (`core_compact`=0), `insn_data` is the full stored word, and `core_take` while valid pops the entry.
- R8: In compact mode (`core_compact`=1), PC bit 1 clear serves the low halfword zero-extended and `core_take` does not pop. PC bit 1 set serves the high halfword zero-extended and `core_take` pops.
- R9: The debug lookup reports the lowest-numbered slot whose stored address equals `{dbg_addr[31:2],2'b00}`. Consumed slots still match their last address. `dbg_hit`=0 means no slot matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_pc | input | 32 | Current program counter |
| core_compact | input | 1 | 1 = 16-bit halfword mode, 0 = word mode |
| core_take | input | 1 | Core consumes the served instruction |
| insn_valid | output | 1 | Served instruction is valid |
| insn_data | output | 32 | Served word or zero-extended halfword |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_addr | output | 32 | Fetch word address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Fetch data returned |
| mem_rsp_data | input | 32 | Fetched word |
| xlat_en | input | 1 | Address translation enabled |
| xlat_fault | input | 1 | Translation fault for the current request |
| dbg_addr | input | 32 | Debug lookup address |
| dbg_hit | output | 1 | A slot matches the lookup |
| dbg_slot | output | 2 | Index of the lowest matching slot |

## Verification
The queue is driven with several input patterns:
- Sequential word-mode streams, which check the word address ordering and the circular slot placement.
- Compact-mode streams stepping by 2, which separate the non-popping low-half read from the popping high-half read.
- Random jumps with random low PC bits, which exercise flushes with a response in flight and the alignment rule.

A random memory-ready signal and a random response latency shift refill timing against consumption. Directed fault windows show:
- the refill stops while a fault is present;
- it stays parked after the fault clears;
- it resumes on a flush;
- the fault is ignored when translation is disabled.

Debug lookups of nearby addresses check slot placement and the lowest-index rule.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

    typedef enum logic [2:0] {
        RF_IDLE,
        RF_REQ,
        RF_WAIT,
        RF_DRAIN,
        RF_FAULT
    } rf_state_e;

endpackage

// File: rtl/ipq_store.sv
module ipq_store #(
    parameter int DEPTH = 3,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_slot,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [IDXW-1:0] rd_slot,
    output logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [AW-1:0]   dbg_addr,
    output logic            dbg_hit,
    output logic [IDXW-1:0] dbg_slot
);

    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic [AW-1:0] dbg_al;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [AW-1:0] addr_q;
        logic [DW-1:0] data_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q <= '0;
                data_q <= '0;
            end else if (wr_en && (wr_slot == IDXW'(g))) begin
                addr_q <= wr_addr;
                data_q <= wr_data;
            end
        end
        assign slot_addr[g] = addr_q;
        assign slot_data[g] = data_q;
    end

    assign rd_addr = slot_addr[rd_slot];
    assign rd_data = slot_data[rd_slot];
    assign dbg_al  = {dbg_addr[AW-1:2], 2'b00};

    // Lowest index wins: scan downward so the last hit written is the lowest.
    always_comb begin
        dbg_hit  = 1'b0;
        dbg_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (slot_addr[i] == dbg_al) begin
                dbg_hit  = 1'b1;
                dbg_slot = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/ipq_read_port.sv
module ipq_read_port #(
    parameter int DEPTH = 3,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HW   = DW / 2
) (
    input  logic [AW-1:0] core_pc,
    input  logic          core_compact,
    input  logic          core_take,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic [AW-1:0] fetch_addr,
    output logic [AW-1:0] pc_al,
    output logic          flush,
    output logic          pop,
    output logic          insn_valid,
    output logic [DW-1:0] insn_data
);

    logic have_entry;
    logic head_match;

    assign pc_al      = {core_pc[AW-1:2], 2'b00};
    assign have_entry = (cnt != '0);
    assign head_match = (head_addr == pc_al);
    assign insn_valid = have_entry && head_match;
    assign flush      = have_entry ? !head_match : (fetch_addr != pc_al);
    assign pop        = core_take && insn_valid && (!core_compact || core_pc[1]);

    always_comb begin
        if (!core_compact) begin
            insn_data = head_data;
        end else if (core_pc[1]) begin
            insn_data = {{(DW-HW){1'b0}}, head_data[DW-1:HW]};
        end else begin
            insn_data = {{(DW-HW){1'b0}}, head_data[HW-1:0]};
        end
    end

endmodule

// File: rtl/ipq_refill_ctl.sv
module ipq_refill_ctl
    import ipq_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int AW    = 32,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            pop,
    input  logic [AW-1:0]   pc_al,
    input  logic            mem_req_ready,
    input  logic            mem_rsp_valid,
    input  logic            xlat_en,
    input  logic            xlat_fault,
    output logic            mem_req_valid,
    output logic [AW-1:0]   mem_req_addr,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_slot,
    output logic [CW-1:0]   cnt,
    output logic [IDXW-1:0] rd_idx,
    output logic [AW-1:0]   fetch_addr
);

    rf_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [IDXW-1:0] idx_q;
    logic [AW-1:0]   fa_q;
    logic            fault_now;
    logic [CW:0]     slot_sum;

    assign fault_now = xlat_en && xlat_fault;
    assign wr_en     = (state_q == RF_WAIT) && mem_rsp_valid && !flush;
    assign cnt_d     = flush ? '0 : (cnt_q + CW'(wr_en) - CW'(pop));
    assign slot_sum  = {1'b0, cnt_q} + (CW+1)'(idx_q);
    assign wr_slot   = (slot_sum >= (CW+1)'(DEPTH)) ? IDXW'(slot_sum - (CW+1)'(DEPTH))
                                                   : IDXW'(slot_sum);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RF_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RF_IDLE:  if (cnt_d < CW'(DEPTH)) state_d = RF_REQ;
            RF_REQ: begin
                if (flush)              state_d = RF_REQ;
                else if (fault_now)     state_d = RF_FAULT;
                else if (mem_req_ready) state_d = RF_WAIT;
            end
            RF_WAIT: begin
                if (mem_rsp_valid) state_d = (cnt_d < CW'(DEPTH)) ? RF_REQ : RF_IDLE;
                else if (flush)    state_d = RF_DRAIN;
            end
            RF_DRAIN: if (mem_rsp_valid)  state_d = RF_REQ;
            RF_FAULT: if (flush || pop)   state_d = RF_REQ;
            default:  state_d = RF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = (state_q == RF_REQ) && !flush && !fault_now;
        mem_req_addr  = fa_q;
    end

    // queue pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            fa_q  <= '0;
        end else if (flush) begin
            cnt_q <= '0;
            idx_q <= '0;
            fa_q  <= pc_al;
        end else begin
            cnt_q <= cnt_d;
            if (wr_en) fa_q <= fa_q + AW'(4);
            if (pop)   idx_q <= (idx_q == IDXW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    assign cnt        = cnt_q;
    assign rd_idx     = idx_q;
    assign fetch_addr = fa_q;

endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue #(
    parameter int DEPTH = 3,
    localparam int AW   = 32,
    localparam int DW   = 32,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   core_pc,
    input  logic            core_compact,
    input  logic            core_take,
    output logic            insn_valid,
    output logic [DW-1:0]   insn_data,
    output logic            mem_req_valid,
    output logic [AW-1:0]   mem_req_addr,
    input  logic            mem_req_ready,
    input  logic            mem_rsp_valid,
    input  logic [DW-1:0]   mem_rsp_data,
    input  logic            xlat_en,
    input  logic            xlat_fault,
    input  logic [AW-1:0]   dbg_addr,
    output logic            dbg_hit,
    output logic [IDXW-1:0] dbg_slot
);

    logic [AW-1:0]   pc_al;
    logic            flush;
    logic            pop;
    logic            wr_en;
    logic [IDXW-1:0] wr_slot;
    logic [CW-1:0]   cnt;
    logic [IDXW-1:0] rd_idx;
    logic [AW-1:0]   fetch_addr;
    logic [AW-1:0]   head_addr;
    logic [DW-1:0]   head_data;

    ipq_refill_ctl #(.DEPTH(DEPTH), .AW(AW)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .pop           (pop),
        .pc_al         (pc_al),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .xlat_en       (xlat_en),
        .xlat_fault    (xlat_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .wr_en         (wr_en),
        .wr_slot       (wr_slot),
        .cnt           (cnt),
        .rd_idx        (rd_idx),
        .fetch_addr    (fetch_addr)
    );

    ipq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_addr  (fetch_addr),
        .wr_data  (mem_rsp_data),
        .rd_slot  (rd_idx),
        .rd_addr  (head_addr),
        .rd_data  (head_data),
        .dbg_addr (dbg_addr),
        .dbg_hit  (dbg_hit),
        .dbg_slot (dbg_slot)
    );

    ipq_read_port #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_rd (
        .core_pc      (core_pc),
        .core_compact (core_compact),
        .core_take    (core_take),
        .cnt          (cnt),
        .head_addr    (head_addr),
        .head_data    (head_data),
        .fetch_addr   (fetch_addr),
        .pc_al        (pc_al),
        .flush        (flush),
        .pop          (pop),
        .insn_valid   (insn_valid),
        .insn_data    (insn_data)
    );

endmodule

// File: rtl/ipq_checker.sv
module ipq_checker #(
    parameter int DEPTH = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_valid,
    input logic          core_take,
    input logic          core_compact,
    input logic [31:0]   core_pc,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          xlat_en,
    input logic          xlat_fault,
    input logic          wr_en,
    input logic [CW-1:0] cnt
);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R4
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R6
    fault_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_en && xlat_fault) |-> !mem_req_valid);

    // R7
    valid_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |-> (cnt != '0));

    // R3
    mismatch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_valid && (cnt != '0)) |=> (cnt == '0));

    // R7
    word_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && core_take && !core_compact && !wr_en) |=> (cnt == $past(cnt) - CW'(1)));

    // R8
    low_half_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && core_take && core_compact && !core_pc[1]) |=> (cnt >= $past(cnt)));

endmodule

bind insn_prefetch_queue ipq_checker #(.DEPTH(DEPTH)) u_ipq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_valid    (insn_valid),
    .core_take     (core_take),
    .core_compact  (core_compact),
    .core_pc       (core_pc),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .xlat_en       (xlat_en),
    .xlat_fault    (xlat_fault),
    .wr_en         (wr_en),
    .cnt           (cnt)
);

// File: tb/insn_prefetch_queue_bench.sv
`timescale 1ns/1ps
module insn_prefetch_queue_bench;
    localparam int DEPTH = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] core_pc;
    logic        core_compact, core_take;
    logic        insn_valid;
    logic [31:0] insn_data;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        xlat_en, xlat_fault;
    logic [31:0] dbg_addr;
    logic        dbg_hit;
    logic [1:0]  dbg_slot;

    always #4 clk = ~clk;

    insn_prefetch_queue #(.DEPTH(DEPTH)) u_insn_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .core_pc(core_pc), .core_compact(core_compact),
        .core_take(core_take), .insn_valid(insn_valid), .insn_data(insn_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .xlat_en(xlat_en), .xlat_fault(xlat_fault),
        .dbg_addr(dbg_addr), .dbg_hit(dbg_hit), .dbg_slot(dbg_slot)
    );

    int n_chk = 0, n_fail = 0;
    // model of the queue
    int          m_cnt, m_idx;
    logic [31:0] m_fa;
    logic [31:0] m_addr [DEPTH];
    bit          m_out, m_stale;
    // responder
    bit          pend;
    int          dly;
    logic [31:0] paddr;
    // consumer / phase control
    bit          adv;
    int          jump_div, fault_div;
    int          cmode;          // 0 word, 1 compact, 2 pick at jump
    bit          xlat_ph;
    bit          force_en;
    logic [31:0] force_pc;
    int          req_seen, valid_seen;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] exp_insn(input logic [31:0] pc, input logic cm);
        logic [31:0] w;
        w = mem_word({pc[31:2], 2'b00});
        if (!cm) return w;
        return pc[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic observe();
        logic [31:0] pc_al, dal;
        bit hit, head_ok, pop, exp_hit;
        int exp_slot, slot;
        pc_al   = {core_pc[31:2], 2'b00};
        head_ok = (m_cnt > 0) && (m_addr[m_idx] == pc_al);
        hit     = (m_cnt > 0) ? head_ok : (m_fa == pc_al);
        chk("R3 R7 insn_valid", {31'b0, insn_valid}, {31'b0, head_ok});
        if (head_ok)
            chk(core_compact ? "R2 R8 halfword" : "R2 R7 word", insn_data, exp_insn(core_pc, core_compact));
        if (mem_req_valid) begin
            req_seen++;
            chk("R4 R6 request allowed", 32'(hit && !m_out && m_cnt < DEPTH && !(xlat_en && xlat_fault)), 32'd1);
            chk("R4 request address", mem_req_addr, m_fa);
        end
        if (insn_valid) valid_seen++;
        dal = {dbg_addr[31:2], 2'b00};
        exp_hit = 0; exp_slot = 0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (m_addr[i] == dal) begin exp_hit = 1; exp_slot = i; end
        chk("R5 R9 dbg_hit", {31'b0, dbg_hit}, {31'b0, exp_hit});
        if (exp_hit) chk("R5 R9 dbg_slot", {30'b0, dbg_slot}, 32'(exp_slot));
        // model advance for the coming edge
        pop = core_take && head_ok && (!core_compact || core_pc[1]);
        adv = core_take && head_ok;
        if (!hit) begin
            if (m_out) begin
                if (mem_rsp_valid) begin m_out = 0; m_stale = 0; end
                else m_stale = 1;
            end
            m_cnt = 0; m_idx = 0; m_fa = pc_al;
        end else begin
            if (mem_rsp_valid && m_out) begin
                if (!m_stale) begin
                    slot = (m_idx + m_cnt) % DEPTH;
                    m_addr[slot] = m_fa;
                    m_fa = m_fa + 4;
                    m_cnt++;
                end
                m_out = 0; m_stale = 0;
            end
            if (pop) begin m_idx = (m_idx + 1) % DEPTH; m_cnt--; end
        end
        if (mem_req_valid && mem_req_ready) begin
            m_out = 1; pend = 1; paddr = mem_req_addr; dly = $urandom % 3;
        end
    endtask

    task automatic drive();
        if (pend && dly == 0) begin
            mem_rsp_valid = 1; mem_rsp_data = mem_word(paddr); pend = 0;
        end else begin
            mem_rsp_valid = 0; mem_rsp_data = $urandom;
            if (pend) dly--;
        end
        mem_req_ready = ($urandom % 4) != 0;
        if (force_en) begin
            core_pc = force_pc; force_en = 0;
        end else if (jump_div != 0 && ($urandom % jump_div) == 0) begin
            if (cmode == 2) core_compact = $urandom % 2;
            else            core_compact = (cmode == 1);
            core_pc = ($urandom & 32'h0000_0FFC) | ($urandom % 4);
        end else if (adv) begin
            core_pc = core_pc + (core_compact ? 32'd2 : 32'd4);
        end
        core_take = ($urandom % 4) != 0;
        xlat_en   = xlat_ph;
        xlat_fault = (fault_div != 0) && (($urandom % fault_div) == 0);
        case ($urandom % 3)
            0: dbg_addr = $urandom & 32'h0000_0FFF;
            default: dbg_addr = core_pc + 32'(($urandom % 4) * 4) - 32'd4;
        endcase
    endtask

    task automatic step();
        @(negedge clk); observe();
        @(posedge clk); #1; drive();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; core_pc = 0; core_compact = 0; core_take = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        xlat_en = 0; xlat_fault = 0; dbg_addr = 0;
        m_cnt = 0; m_idx = 0; m_fa = 0; m_out = 0; m_stale = 0;
        for (int i = 0; i < DEPTH; i++) m_addr[i] = 0;
        pend = 0; dly = 0; paddr = 0; adv = 0;
        jump_div = 0; fault_div = 0; cmode = 0; xlat_ph = 0; force_en = 0; force_pc = 0;
        req_seen = 0; valid_seen = 0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset insn_valid", {31'b0, insn_valid}, 32'd0);
            chk("R1 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        end
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk("R1 cleared address hit", {31'b0, dbg_hit}, 32'd1);
        chk("R1 cleared address slot", {30'b0, dbg_slot}, 32'd0);
        @(posedge clk); #1; drive();

        // sequential word mode
        cmode = 0; jump_div = 0; repeat (400) step();
        // word mode with random jumps
        jump_div = 25; repeat (3000) step();
        // compact mode
        cmode = 1; repeat (3000) step();
        // mixed modes with translation and sporadic faults
        cmode = 2; xlat_ph = 1; fault_div = 30; repeat (3000) step();

        // directed: persistent fault stops refill (R6)
        cmode = 0; jump_div = 0; fault_div = 1; xlat_ph = 1;
        force_pc = 32'h800; force_en = 1; step();
        req_seen = 0; repeat (30) step();
        chk("R6 no request under fault", 32'(req_seen), 32'd0);
        // fault cleared: refill stays parked
        fault_div = 0; req_seen = 0; repeat (12) step();
        chk("R6 parked after fault", 32'(req_seen), 32'd0);
        // flush resumes refill
        force_pc = 32'h900; force_en = 1; step();
        valid_seen = 0; repeat (40) step();
        chk("R3 R6 resume after flush", 32'(valid_seen > 0), 32'd1);
        // fault ignored when translation disabled
        xlat_ph = 0; fault_div = 1; force_pc = 32'hA00; force_en = 1; step();
        valid_seen = 0; repeat (40) step();
        chk("R6 fault ignored when disabled", 32'(valid_seen > 0), 32'd1);
        fault_div = 0; cmode = 1; jump_div = 40; repeat (1000) step();
        summary();
    end
endmodule